// File: doc/BRIEF.md
# Integer Shift and Rotate Unit

This is a purely combinational shifter for the execute stage of a 32-bit integer pipeline. It receives the decoded function code, the immediate shift-amount field, the three register-specifier fields and the two source operand values. It produces the destination value, a write enable and two indications: an illegal-code flag and a two-bit no-op class.

Eight operations are covered: logical left, logical right, arithmetic right and right rotate. Each comes in an immediate-amount form and a register-amount form. Rotate is not given a function code of its own. It shares a code with logical right shift, and one spare bit of the instruction word chooses between the two.

The all-zero instruction word, and the two barrier-style no-ops that differ from it only in the amount field, are classified and reported on the class output. The unit does not act on them: it only reports the class. Fetch, register access, hazards and writeback happen elsewhere.

Top module: `shift_rot_unit`

## Requirements
- R1: Function code 0x00 shifts `rt_val` left by `sa_amt` and fills vacated low bits with zeros.
- R2: Function code 0x02 with `rs_field[0]`=0 shifts `rt_val` right by `sa_amt` and fills vacated high bits with zeros.
- R3: Function code 0x02 with `rs_field[0]`=1 rotates `rt_val` right by `sa_amt`. Bits leaving bit 0 re-enter at bit 31, so a rotate by 0 returns `rt_val` unchanged.
- R4: Function codes 0x03 (immediate amount) and 0x07 (register amount) shift `rt_val` right and fill vacated high bits with copies of `rt_val[31]`.
- R5: Function codes 0x04, 0x06 and 0x07 take the amount from `rs_val` modulo 32, so any value of 32 or more wraps. `sa_amt` has no effect on the amount of these forms.
- R6: Function code 0x06 rotates right when `sa_amt[0]`=1 and shifts right logically when `sa_amt[0]`=0.
- R7: In every form, an amount of 0 passes `rt_val` through unchanged.
- R8: Function code 0x00 with `rs_field`, `rt_field` and `rd_field` all zero is a no-op. The class output is then 2'b10 for `sa_amt`=1, 2'b11 for `sa_amt`=3, and 2'b01 for any other amount. For a no-op, `wr_en` is 0 and `rd_val` is 0.
- R9: Any function code other than 0x00, 0x02, 0x03, 0x04, 0x06 and 0x07 raises `illegal`. It also forces `rd_val` to 0, `wr_en` to 0 and the class output to 2'b00.
- R10: A legal code that is not a no-op drives `wr_en`=1, `illegal`=0 and class 2'b00. Exactly one of `illegal`, `wr_en` and a nonzero class is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fn_code | input | 6 | Function code of the instruction |
| sa_amt | input | 5 | Immediate shift-amount field |
| rs_field | input | 5 | rs register-specifier field |
| rt_field | input | 5 | rt register-specifier field |
| rd_field | input | 5 | rd register-specifier field |
| rs_val | input | 32 | rs operand value, used as the amount source for register forms |
| rt_val | input | 32 | Operand that is shifted or rotated |
| rd_val | output | 32 | Result value |
| wr_en | output | 1 | Result must be written to the destination |
| illegal | output | 1 | Function code is not a shift code |
| nop_class | output | 2 | 00 none, 01 plain no-op, 10 superscalar no-op, 11 hazard barrier |

## Verification
The bench builds the unit at its default width of 32 bits, which makes the whole amount range small enough to sweep exhaustively. Every amount from 0 to 31 is applied to all eight operations, with the operands 0x80000000, 0xFFFFFFFF and random words. This covers the sign-fill boundary, full wrap-around of the rotate, and the zero-amount pass-through. The register forms are also given `rs_val` values of 32 and above, so the modulo wrap and the unused immediate field are both visible at the result.

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int W    = 32,
  parameter int REGW = 5,
  parameter int FNW  = 6
) (
  input  logic [FNW-1:0]          fn_code,
  input  logic [$clog2(W)-1:0]    sa_amt,
  input  logic [REGW-1:0]         rs_field,
  input  logic [REGW-1:0]         rt_field,
  input  logic [REGW-1:0]         rd_field,
  input  logic [W-1:0]            rs_val,
  input  logic [W-1:0]            rt_val,
  output logic [W-1:0]            rd_val,
  output logic                    wr_en,
  output logic                    illegal,
  output logic [1:0]              nop_class
);
  localparam int SHW = $clog2(W);

  typedef enum logic [1:0] {K_SLL, K_SRL, K_ROR, K_SRA} kind_t;

  kind_t        kind;
  logic         legal;
  logic         use_reg;
  logic [W-1:0] amt;
  logic [W-1:0] shifted;
  logic [2*W-1:0] funnel;
  logic         all_zero;

  always_comb begin
    legal   = 1'b1;
    use_reg = 1'b0;
    kind    = K_SLL;
    case (fn_code)
      FNW'(6'h00): kind = K_SLL;
      FNW'(6'h02): kind = rs_field[0] ? K_ROR : K_SRL;
      FNW'(6'h03): kind = K_SRA;
      FNW'(6'h04): begin kind = K_SLL; use_reg = 1'b1; end
      FNW'(6'h06): begin kind = sa_amt[0] ? K_ROR : K_SRL; use_reg = 1'b1; end
      FNW'(6'h07): begin kind = K_SRA; use_reg = 1'b1; end
      default:     legal = 1'b0;
    endcase
  end

  assign amt    = use_reg ? (rs_val % W) : W'(sa_amt);
  assign funnel = {rt_val, rt_val} >> amt;

  always_comb begin
    case (kind)
      K_SLL:   shifted = rt_val << amt;
      K_SRL:   shifted = rt_val >> amt;
      K_ROR:   shifted = funnel[W-1:0];
      default: shifted = W'($signed(rt_val) >>> amt);
    endcase
  end

  assign all_zero = (fn_code == '0) && (rs_field == '0) &&
                    (rt_field == '0) && (rd_field == '0);

  always_comb begin
    nop_class = 2'b00;
    if (all_zero) begin
      if (sa_amt == SHW'(1))      nop_class = 2'b10;
      else if (sa_amt == SHW'(3)) nop_class = 2'b11;
      else                        nop_class = 2'b01;
    end
  end

  assign wr_en   = legal && (nop_class == 2'b00);
  assign illegal = !legal;
  assign rd_val  = wr_en ? shifted : '0;
endmodule

// File: rtl/shift_rot_unit_chk.sv
module shift_rot_unit_chk #(
  parameter int W   = 32,
  parameter int FNW = 6
) (
  input logic [FNW-1:0]       fn_code,
  input logic [$clog2(W)-1:0] sa_amt,
  input logic [W-1:0]         rt_val,
  input logic [W-1:0]         rd_val,
  input logic                 wr_en,
  input logic                 illegal,
  input logic [1:0]           nop_class
);
  always_comb begin
    AST_SLL_ZERO_FILL: assert (!(wr_en && fn_code == FNW'(6'h00) && sa_amt != '0) || !rd_val[0])
      else $error("sll low bit not zero"); // R1
    AST_ZERO_AMT_PASS: assert (!(wr_en && fn_code == FNW'(6'h02) && sa_amt == '0) || rd_val == rt_val)
      else $error("zero amount changed operand"); // R3
    AST_SRA_SIGN_FILL: assert (!(wr_en && (fn_code == FNW'(6'h03) || fn_code == FNW'(6'h07)) && rt_val[W-1]) || rd_val[W-1])
      else $error("arith shift lost sign"); // R4
    AST_NOP_NO_WRITE: assert (nop_class == 2'b00 || (!wr_en && rd_val == '0))
      else $error("no-op wrote result"); // R8
    AST_ILLEGAL_QUIET: assert (!illegal || (!wr_en && rd_val == '0 && nop_class == 2'b00))
      else $error("illegal code not quiet"); // R9
    AST_ONE_OUTCOME: assert ($onehot({illegal, wr_en, nop_class != 2'b00}))
      else $error("outcomes not exclusive"); // R10
  end
endmodule

bind shift_rot_unit shift_rot_unit_chk #(.W(W), .FNW(FNW)) u_chk (
  .fn_code(fn_code), .sa_amt(sa_amt), .rt_val(rt_val), .rd_val(rd_val),
  .wr_en(wr_en), .illegal(illegal), .nop_class(nop_class)
);

// File: tb/sim_shift_rot_unit.sv
`timescale 1ns/1ps
module sim_shift_rot_unit;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [5:0]   fn_code = '0;
  logic [4:0]   sa_amt = '0, rs_field = '0, rt_field = '0, rd_field = '0;
  logic [W-1:0] rs_val = '0, rt_val = '0;
  logic [W-1:0] rd_val;
  logic         wr_en, illegal;
  logic [1:0]   nop_class;

  shift_rot_unit u0 (
    .fn_code(fn_code), .sa_amt(sa_amt), .rs_field(rs_field), .rt_field(rt_field),
    .rd_field(rd_field), .rs_val(rs_val), .rt_val(rt_val), .rd_val(rd_val),
    .wr_en(wr_en), .illegal(illegal), .nop_class(nop_class)
  );

  typedef struct {
    logic [W-1:0] rd;
    logic         wr;
    logic         ill;
    logic [1:0]   cls;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [W-1:0] model(int kind, logic [W-1:0] v, int n);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      case (kind)
        0: r[i] = (i - n >= 0) ? v[i-n] : 1'b0;
        1: r[i] = (i + n < W) ? v[i+n] : 1'b0;
        2: r[i] = v[(i+n) % W];
        default: r[i] = (i + n < W) ? v[i+n] : v[W-1];
      endcase
    end
    return r;
  endfunction

  task automatic drive(input logic [5:0] f, input logic [4:0] sa, input logic [4:0] rsf,
                       input logic [4:0] rtf, input logic [4:0] rdf, input logic [W-1:0] rsv,
                       input logic [W-1:0] rtv, input logic [W-1:0] erd, input logic ewr,
                       input logic eill, input logic [1:0] ecls, input string tag);
    exp_t e;
    @(posedge clk);
    fn_code = f; sa_amt = sa; rs_field = rsf; rt_field = rtf; rd_field = rdf;
    rs_val = rsv; rt_val = rtv;
    e.rd = erd; e.wr = ewr; e.ill = eill; e.cls = ecls; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (rd_val !== e.rd || wr_en !== e.wr || illegal !== e.ill || nop_class !== e.cls) begin
          errors++;
          $display("FAIL %s: got rd=%h wr=%b ill=%b cls=%b, expected rd=%h wr=%b ill=%b cls=%b",
                   e.tag, rd_val, wr_en, illegal, nop_class, e.rd, e.wr, e.ill, e.cls);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ops[4];
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset-state inputs are all zero: plain no-op class (R8)
    drive(6'h00, 5'd0, 5'd0, 5'd0, 5'd0, '0, '0, '0, 1'b0, 1'b0, 2'b01, "R8 reset state");

    for (int kind = 0; kind < 4; kind++) begin
      for (int rg = 0; rg < 2; rg++) begin
        for (int n = 0; n < W; n++) begin
          ops[0] = 32'h8000_0000; ops[1] = 32'hFFFF_FFFF; ops[2] = $urandom; ops[3] = $urandom;
          for (int k = 0; k < 4; k++) begin
            logic [5:0] f;
            logic [4:0] sa, rsf;
            logic [W-1:0] rsv;
            string tag;
            if (rg == 0) begin
              f   = (kind == 0) ? 6'h00 : (kind == 3) ? 6'h03 : 6'h02;
              sa  = 5'(n);
              rsf = (kind == 2) ? 5'd1 : 5'd0;
              rsv = $urandom;
              tag = (n == 0) ? "R7 zero amount" :
                    (kind == 0) ? "R1 sll" : (kind == 1) ? "R2 srl" :
                    (kind == 2) ? "R3 rotr" : "R4 sra";
            end else begin
              f   = (kind == 0) ? 6'h04 : (kind == 3) ? 6'h07 : 6'h06;
              sa  = 5'($urandom);
              if (kind == 1) sa[0] = 1'b0;
              if (kind == 2) sa[0] = 1'b1;
              rsf = 5'd9;
              rsv = W'(n) + W'(32 * (k + ($urandom % 64)));
              tag = (kind == 2) ? "R6 rotrv" : (kind == 1) ? "R6 srlv" :
                    (n == 0) ? "R7 zero var amount" : "R5 variable wrap";
            end
            drive(f, sa, rsf, 5'd4, 5'd3, rsv, ops[k], model(kind, ops[k], n),
                  1'b1, 1'b0, 2'b00, tag);
          end
        end
      end
    end

    // No-op classes (R8)
    drive(6'h00, 5'd1, 5'd0, 5'd0, 5'd0, '0, '0, '0, 1'b0, 1'b0, 2'b10, "R8 ssnop");
    drive(6'h00, 5'd3, 5'd0, 5'd0, 5'd0, '0, '0, '0, 1'b0, 1'b0, 2'b11, "R8 ehb");
    drive(6'h00, 5'd2, 5'd0, 5'd0, 5'd0, $urandom, '0, '0, 1'b0, 1'b0, 2'b01, "R8 other amount");
    drive(6'h00, 5'd0, 5'd0, 5'd0, 5'd0, '0, '0, '0, 1'b0, 1'b0, 2'b01, "R8 nop");
    // Nonzero rd field: a real shift, not a no-op (R10)
    drive(6'h00, 5'd1, 5'd0, 5'd0, 5'd2, '0, 32'h0000_00F0, 32'h0000_01E0, 1'b1, 1'b0, 2'b00, "R10 sll rd nonzero");
    drive(6'h00, 5'd3, 5'd1, 5'd0, 5'd0, '0, 32'h0000_0008, 32'h0000_0040, 1'b1, 1'b0, 2'b00, "R10 sll rs nonzero");
    // Illegal codes (R9)
    drive(6'h01, 5'd4, 5'd1, 5'd2, 5'd3, 32'h5, 32'hFFFF_FFFF, '0, 1'b0, 1'b1, 2'b00, "R9 code 01");
    drive(6'h05, 5'd4, 5'd1, 5'd2, 5'd3, 32'h5, 32'hFFFF_FFFF, '0, 1'b0, 1'b1, 2'b00, "R9 code 05");
    drive(6'h20, 5'd0, 5'd0, 5'd0, 5'd0, 32'h5, 32'h1234_5678, '0, 1'b0, 1'b1, 2'b00, "R9 code 20");
    drive(6'h3F, 5'd1, 5'd0, 5'd0, 5'd0, 32'h5, 32'h1234_5678, '0, 1'b0, 1'b1, 2'b00, "R9 code 3F");

    repeat (3) @(posedge clk);
    while (q.size() > 0) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule